// File: doc/BRIEF.md
# Global Exception Status and Clear

This block gathers global exception requests from two processing engines and from one memory self-test checker into a single status register, and drives one global exception output toward the host interrupt controller. Each engine reports three kinds of event: a watchdog expiry, an exception raised on purpose by its microcode, and the decode of an illegal instruction. The memory checker reports a signature mismatch. Every event arrives as a one-cycle hardware pulse and sets a sticky flag.

Software reads the flags through a simple register port. It cannot clear flags one at a time. A single write-one command bit wipes every grouped flag together and drops the global exception output. The command bit does not hold a value and always reads back as zero. When a hardware event arrives in the same cycle as a clear, the event is kept, so no request is lost.

Top module: `gex_status`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_data` is all zero and `gexc_irq` is 0.
- R2: A pulse on `wdog_evt[e]` sets the watchdog flag of engine e at `rd_data` bit 1+e (bits 1 and 2), visible from the cycle after the pulse.
- R3: A pulse on `ucode_evt[e]` sets the microcode exception flag of engine e at `rd_data` bit 3+e (bits 3 and 4).
- R4: A pulse on `illeg_evt[e]` sets the illegal-instruction flag of engine e at `rd_data` bit 5+e (bits 5 and 6).
- R5: A pulse on `sig_miss_evt` sets the signature-mismatch flag at `rd_data` bit 7.
- R6: Once set, a flag stays set in every later cycle until a clear command is written.
- R7: A write (`wr_en`=1) with `wr_data` bit 0 = 1 clears all flags and drops `gexc_irq` from the next cycle on.
- R8: A write with `wr_data` bit 0 = 0 changes no flag, whatever the other written bits hold.
- R9: `rd_data` bit 0, the clear command bit, always reads 0, and `rd_data` bits above 7 read 0.
- R10: When a set event and a clear command fall in the same cycle, the flag of that event is set in the next cycle, while all other flags are cleared.
- R11: `gexc_irq` is 1 exactly when at least one flag in `rd_data` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 0 is the global clear command |
| rd_data | output | 32 | Status read data: bit 0 zero, flags in bits 1 to 7 |
| wdog_evt | input | 2 | Watchdog expiry pulse, one bit per engine |
| ucode_evt | input | 2 | Microcode exception pulse, one bit per engine |
| illeg_evt | input | 2 | Illegal-instruction pulse, one bit per engine |
| sig_miss_evt | input | 1 | Memory signature-mismatch pulse |
| gexc_irq | output | 1 | Global exception request |

## Verification
The two functions that meet in one cycle are a hardware set event and the global clear write. The bench provokes the collision with a directed case that pulses one source while writing the clear bit with other flags already pending, and then with a random run where sparse event pulses and clear writes land together often. Each result is judged against a bench model where the set term takes priority over the clear term, flag by flag, so a lost event or a flag that survives a clear is caught.

// File: rtl/gex_pkg.sv
package gex_pkg;
  // Flag layout in the status word: bit 0 is the command bit,
  // then per-engine watchdog, microcode, illegal groups, then mismatch.
  function automatic int wdog_pos(input int e);
    return 1 + e;
  endfunction

  function automatic int ucode_pos(input int e, input int n_eng);
    return 1 + n_eng + e;
  endfunction

  function automatic int illeg_pos(input int e, input int n_eng);
    return 1 + 2 * n_eng + e;
  endfunction

  function automatic int miss_pos(input int n_eng);
    return 1 + 3 * n_eng;
  endfunction

  localparam int CLR_BIT = 0;
endpackage

// File: rtl/gex_cmd_decode.sv
module gex_cmd_decode #(
  parameter int DW = 32
) (
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          clr_cmd
);
  import gex_pkg::*;

  logic unused_wr_hi;

  always_comb begin
    clr_cmd = wr_en & wr_data[CLR_BIT];
  end

  assign unused_wr_hi = ^wr_data[DW-1:1];
endmodule

// File: rtl/gex_src_map.sv
module gex_src_map #(
  parameter int NUM_ENG = 2,
  localparam int FLAG_W = 3 * NUM_ENG + 1
) (
  input  logic [NUM_ENG-1:0] wdog_evt,
  input  logic [NUM_ENG-1:0] ucode_evt,
  input  logic [NUM_ENG-1:0] illeg_evt,
  input  logic               sig_miss_evt,
  output logic [FLAG_W-1:0]  set_vec
);
  import gex_pkg::*;

  // Positions inside the flag vector are status positions minus one.
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    assign set_vec[wdog_pos(e) - 1]           = wdog_evt[e];
    assign set_vec[ucode_pos(e, NUM_ENG) - 1] = ucode_evt[e];
    assign set_vec[illeg_pos(e, NUM_ENG) - 1] = illeg_evt[e];
  end
  assign set_vec[miss_pos(NUM_ENG) - 1] = sig_miss_evt;
endmodule

// File: rtl/gex_flag_bank.sv
module gex_flag_bank #(
  parameter int FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              clr_cmd,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_nxt;
  logic              flags_en;

  // Set term has priority over the shared clear term.
  always_comb begin
    flags_en  = clr_cmd | (|set_vec);
    flags_nxt = set_vec | (clr_cmd ? '0 : flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_nxt;
    end
  end
endmodule

// File: rtl/gex_status.sv
module gex_status #(
  parameter int NUM_ENG = 2,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [NUM_ENG-1:0] wdog_evt,
  input  logic [NUM_ENG-1:0] ucode_evt,
  input  logic [NUM_ENG-1:0] illeg_evt,
  input  logic               sig_miss_evt,
  output logic               gexc_irq
);
  localparam int FLAG_W = 3 * NUM_ENG + 1;
  localparam int PAD_W  = DW - FLAG_W - 1;

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags;
  logic              clr_cmd;

  gex_cmd_decode #(.DW(DW)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_cmd (clr_cmd)
  );

  gex_src_map #(.NUM_ENG(NUM_ENG)) u_map (
    .wdog_evt     (wdog_evt),
    .ucode_evt    (ucode_evt),
    .illeg_evt    (illeg_evt),
    .sig_miss_evt (sig_miss_evt),
    .set_vec      (set_vec)
  );

  gex_flag_bank #(.FLAG_W(FLAG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_cmd (clr_cmd),
    .flags   (flags)
  );

  always_comb begin
    rd_data  = {{PAD_W{1'b0}}, flags, 1'b0};
    gexc_irq = |flags;
  end
endmodule

// File: rtl/gex_status_chk.sv
module gex_status_chk #(
  parameter int NUM_ENG = 2,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [DW-1:0]      wr_data,
  input logic [DW-1:0]      rd_data,
  input logic [NUM_ENG-1:0] wdog_evt,
  input logic [NUM_ENG-1:0] ucode_evt,
  input logic [NUM_ENG-1:0] illeg_evt,
  input logic               sig_miss_evt,
  input logic               gexc_irq
);
  logic any_evt;
  assign any_evt = (|wdog_evt) | (|ucode_evt) | (|illeg_evt) | sig_miss_evt;

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    gexc_irq == (rd_data != '0)); // R11

  AST_CMD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] == 1'b0); // R9

  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !any_evt) |=> (rd_data == '0 && !gexc_irq)); // R7

  AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[0]) |=> ((rd_data & $past(rd_data)) == $past(rd_data))); // R6

  AST_WDOG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt[0] |=> rd_data[1]); // R10

  AST_MISS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sig_miss_evt |=> rd_data[3 * NUM_ENG + 1]); // R5
endmodule

bind gex_status gex_status_chk #(.NUM_ENG(NUM_ENG), .DW(DW)) u_chk (.*);

// File: tb/sim_gex_status.sv
module sim_gex_status;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [1:0]  wdog_evt;
  logic [1:0]  ucode_evt;
  logic [1:0]  illeg_evt;
  logic        sig_miss_evt;
  logic        gexc_irq;

  int checks;
  int errs;
  logic [6:0] model;

  gex_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdog_evt(wdog_evt), .ucode_evt(ucode_evt),
    .illeg_evt(illeg_evt), .sig_miss_evt(sig_miss_evt), .gexc_irq(gexc_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Layout from the requirements: wdog bits 1,2; ucode 3,4; illegal 5,6; mismatch 7.
  function automatic logic [6:0] set_of(input logic [1:0] wd, input logic [1:0] uc,
                                        input logic [1:0] il, input logic sg);
    return {sg, il, uc, wd};
  endfunction

  function automatic logic [6:0] next_of(input logic [6:0] cur, input logic [6:0] st,
                                         input logic clr);
    return st | (clr ? 7'd0 : cur);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] wd, input logic [1:0] uc, input logic [1:0] il,
                      input logic sg, input logic we, input logic [31:0] wdat,
                      input string tag);
    wdog_evt = wd; ucode_evt = uc; illeg_evt = il; sig_miss_evt = sg;
    wr_en = we; wr_data = wdat;
    @(posedge clk);
    model = next_of(model, set_of(wd, uc, il, sg), we & wdat[0]);
    @(negedge clk);
    wdog_evt = '0; ucode_evt = '0; illeg_evt = '0; sig_miss_evt = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    check(tag, rd_data, {24'd0, model, 1'b0});
    check("R11", {31'd0, gexc_irq}, {31'd0, |model});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    checks = 0; errs = 0; model = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    wdog_evt = '0; ucode_evt = '0; illeg_evt = '0; sig_miss_evt = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'd0);
    check("R1", {31'd0, gexc_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 32'd0);

    step(2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 32'd0, "R2");
    step(2'b10, 2'b00, 2'b00, 1'b0, 1'b0, 32'd0, "R2");
    step(2'b00, 2'b01, 2'b00, 1'b0, 1'b0, 32'd0, "R3");
    step(2'b00, 2'b10, 2'b00, 1'b0, 1'b0, 32'd0, "R3");
    step(2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 32'd0, "R4");
    step(2'b00, 2'b00, 2'b10, 1'b0, 1'b0, 32'd0, "R4");
    step(2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 32'd0, "R5");
    check("R5", rd_data, 32'h0000_00FE);
    step(2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 32'd0, "R6");
    step(2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 32'hFFFF_FFFE, "R8");
    check("R9", {31'd0, rd_data[0]}, 32'd0);
    step(2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 32'h0000_0001, "R7");
    check("R7", {31'd0, gexc_irq}, 32'd0);
    step(2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 32'd0, "R2");
    step(2'b00, 2'b00, 2'b10, 1'b0, 1'b1, 32'hFFFF_FFFF, "R10");
    check("R10", rd_data, 32'h0000_0040);
    step(2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 32'h0000_0001, "R10");
    check("R9", rd_data & 32'hFFFF_FF01, 32'd0);

    void'($urandom(32'h0000_5EED));
    for (int i = 0; i < 400; i++) begin
      logic [6:0] ev;
      logic       we;
      logic [31:0] wd;
      for (int b = 0; b < 7; b++) ev[b] = ($urandom_range(0, 7) == 0);
      we = ($urandom_range(0, 4) == 0);
      wd = $urandom;
      if ($urandom_range(0, 1) == 0) wd[0] = 1'b0;
      step(ev[1:0], ev[3:2], ev[5:4], ev[6], we, wd, "R6");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule